// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Arbiter

This block holds the interrupt bookkeeping shared by the two channels of a serial controller. Channel A is index 1 and channel B is index 0 in every per-channel port. Each channel keeps a receive-pending flag and a transmit-pending flag. It also has a small service machine that records whether a receive or a transmit interrupt is under service. The block combines these flags with the channel's enable settings and its break status into one active-high interrupt request.

The block also drives two readable values. The first is a pending-bits byte that software reads through channel A. The second is a modified interrupt vector that software reads through channel B. The vector shows the most recently presented event and its channel, in either a low or a high bit placement.

Events reach the block as single-cycle strobes:
- received character available
- transmit buffer loaded
- transmit buffer empty
- receive data read
- clear-transmit-pending command
- reset-under-service command

A receive interrupt that is under service holds back the presentation of a transmit interrupt. Clearing one source presents the other again if it is still pending.

Each channel's service machine has four states. SVC_IDLE means nothing is under service. SVC_RX means receive is under service. SVC_TX means transmit is under service. SVC_BOTH means both are under service.

The transitions are named as follows:
- "rx present" sets the receive half of the state.
- "tx present" sets the transmit half, but only when the receive half is clear.
- "rx clear" (data read) drops the receive half.
- "tx clear" drops the transmit half.
- "service reset" drops the receive half if it is set, and otherwise drops the transmit half.

Top module: `dual_irq_vec_arb`

## Requirements
- R1: After reset, irq is 0, pend_bits reads 0x00, vector reads 0x00, and both channels are idle with nothing pending.
- R2: irq is the OR over both channels of three terms: (tx_ie and transmit pending), (rx_mode equal to 01 or 10 and receive pending), and (brk_ie and brk_stat). rx_mode values 00 and 11 do not enable the receive term. irq is combinational from the registered flags and the current enables.
- R3: pend_bits has the following layout. Bit 5 is A receive and bit 4 is A transmit. Bit 2 is B receive and bit 1 is B transmit. Bits 0, 3, 6 and 7 always read 0.
- R4: vector is loaded with a value chosen by event and channel. With status_hi = 0 the values are: none 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00. With status_hi = 1 the values are: none 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00. status_hi is sampled in the cycle the vector is loaded.
- R5: A rx_set strobe does four things: it sets receive pending, sets receive-under-service, sets the channel's receive bit in pend_bits, and loads the receive vector. All of this is visible after the next clock edge.
- R6: A tx_empty strobe always sets transmit pending. If receive is not under service, it also does three things: it sets transmit-under-service, loads the transmit vector, and sets the pend_bits transmit bit when tx_ie is 1. If receive is under service, it changes nothing else.
- R7: An rx_clr strobe does four things: it clears receive pending, clears receive-under-service, clears the receive pend_bits bit, and loads the no-interrupt vector. If transmit is still pending, the transmit presentation of R6 then follows in the same cycle.
- R8: A tx_clr strobe does four things: it clears transmit pending, clears transmit-under-service, clears the transmit pend_bits bit, and loads the no-interrupt vector. If receive is still pending, the receive presentation of R5 then follows in the same cycle.
- R9: A svc_rst strobe acts as follows. If receive is under service, it clears that state and presents a pending transmit interrupt as in R6. Otherwise it clears transmit-under-service.
- R10: A tx_load strobe clears transmit pending only. pend_bits and vector do not change.
- R11: Within a channel, strobes in the same cycle apply in this order: rx_set, tx_load, tx_empty, rx_clr, tx_clr, svc_rst. When both channels load the vector in the same cycle, channel A's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_hi | input | 1 | Selects the high vector bit placement |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel (B in [1:0], A in [3:2]) |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break condition status per channel |
| rx_set | input | 2 | Received character available strobe |
| rx_clr | input | 2 | Receive data read strobe |
| tx_empty | input | 2 | Transmit buffer empty strobe |
| tx_load | input | 2 | Transmit buffer loaded strobe |
| tx_clr | input | 2 | Clear transmit pending command strobe |
| svc_rst | input | 2 | Reset-under-service command strobe |
| irq | output | 1 | Interrupt request, active high |
| pend_bits | output | 8 | Pending bits byte |
| vector | output | 8 | Modified interrupt vector |

## Verification
The hardest situations to reach are the re-presentation paths. In one, a transmit interrupt held back by receive service must surface when the receive side is cleared or reset. In the other, a receive interrupt must come back when a transmit clear arrives. The stimulus reaches these states by first raising receive and then raising transmit while receive is still under service. It then checks the blocked vector before applying rx_clr, svc_rst or tx_clr. A long random strobe sweep follows, with enables and status_hi changing as well. It drives same-cycle collisions within a channel and across channels, and it checks every output each cycle against an arithmetic model of the ordered update rules.

// File: rtl/dual_irq_vec_pkg.sv
package dual_irq_vec_pkg;
    typedef enum logic [1:0] {
        VK_NONE = 2'b00,
        VK_RX   = 2'b01,
        VK_TX   = 2'b10
    } vkind_e;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'b00,
        SVC_RX   = 2'b01,
        SVC_TX   = 2'b10,
        SVC_BOTH = 2'b11
    } svc_e;
endpackage

// File: rtl/dual_irq_vec_chan.sv
module dual_irq_vec_chan
    import dual_irq_vec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_ie,
    input  logic [1:0] rx_mode,
    input  logic       brk_ie,
    input  logic       brk_stat,
    input  logic       rx_set,
    input  logic       rx_clr,
    input  logic       tx_empty,
    input  logic       tx_load,
    input  logic       tx_clr,
    input  logic       svc_rst,
    output logic       irq_c,
    output logic       pb_rx,
    output logic       pb_tx,
    output logic       vec_wr,
    output vkind_e     vec_kind
);
    svc_e svc_q, svc_d;
    logic rxp_q, txp_q, pbr_q, pbt_q;
    logic rxp_d, txp_d, pbr_d, pbt_d;
    logic rs, ts;

    // next-state and vector-load decision, applied in the R11 order
    always_comb begin
        unique case (svc_q)
            SVC_IDLE: begin rs = 1'b0; ts = 1'b0; end
            SVC_RX:   begin rs = 1'b1; ts = 1'b0; end
            SVC_TX:   begin rs = 1'b0; ts = 1'b1; end
            SVC_BOTH: begin rs = 1'b1; ts = 1'b1; end
            default:  begin rs = 1'b0; ts = 1'b0; end
        endcase
        rxp_d    = rxp_q;
        txp_d    = txp_q;
        pbr_d    = pbr_q;
        pbt_d    = pbt_q;
        vec_wr   = 1'b0;
        vec_kind = VK_NONE;
        if (rx_set) begin
            rxp_d = 1'b1; rs = 1'b1; pbr_d = 1'b1;
            vec_wr = 1'b1; vec_kind = VK_RX;
        end
        if (tx_load) txp_d = 1'b0;
        if (tx_empty) begin
            txp_d = 1'b1;
            if (!rs) begin
                ts = 1'b1;
                if (tx_ie) pbt_d = 1'b1;
                vec_wr = 1'b1; vec_kind = VK_TX;
            end
        end
        if (rx_clr) begin
            rxp_d = 1'b0; rs = 1'b0; pbr_d = 1'b0;
            vec_wr = 1'b1; vec_kind = VK_NONE;
            if (txp_d) begin
                ts = 1'b1;
                if (tx_ie) pbt_d = 1'b1;
                vec_kind = VK_TX;
            end
        end
        if (tx_clr) begin
            txp_d = 1'b0; ts = 1'b0; pbt_d = 1'b0;
            vec_wr = 1'b1; vec_kind = VK_NONE;
            if (rxp_d) begin
                rs = 1'b1; pbr_d = 1'b1;
                vec_kind = VK_RX;
            end
        end
        if (svc_rst) begin
            if (rs) begin
                rs = 1'b0;
                if (txp_d) begin
                    ts = 1'b1;
                    if (tx_ie) pbt_d = 1'b1;
                    vec_wr = 1'b1; vec_kind = VK_TX;
                end
            end else begin
                ts = 1'b0;
            end
        end
        svc_d = svc_e'({ts, rs});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= SVC_IDLE;
            rxp_q <= 1'b0;
            txp_q <= 1'b0;
            pbr_q <= 1'b0;
            pbt_q <= 1'b0;
        end else begin
            svc_q <= svc_d;
            rxp_q <= rxp_d;
            txp_q <= txp_d;
            pbr_q <= pbr_d;
            pbt_q <= pbt_d;
        end
    end

    // outputs
    always_comb begin
        irq_c = (tx_ie & txp_q)
              | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & rxp_q)
              | (brk_ie & brk_stat);
        pb_rx = pbr_q;
        pb_tx = pbt_q;
    end

    a_r5_rx_present: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set && !rx_clr && !svc_rst) |=> (rxp_q && svc_q[0]));
    a_r6_tx_held_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && svc_q == SVC_RX && !rx_clr && !tx_clr && !svc_rst) |=> (svc_q[1] == 1'b0));
    a_r7_rx_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> !rxp_q);
    a_r10_load_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_empty) |=> !txp_q);
endmodule

// File: rtl/dual_irq_vec_enc.sv
module dual_irq_vec_enc
    import dual_irq_vec_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  vkind_e           kind,
    input  logic             chan_a,
    input  logic             hi,
    output logic [VEC_W-1:0] vec
);
    logic [2:0] code;

    // 3-bit code: [2] channel A event, [1] receive or none, [0] none
    always_comb begin
        code[0] = (kind == VK_NONE);
        code[1] = (kind == VK_RX) || (kind == VK_NONE);
        code[2] = chan_a && (kind != VK_NONE);
        vec = '0;
        if (hi) vec[6:4] = {code[0], code[1], code[2]};
        else    vec[3:1] = code;
    end
endmodule

// File: rtl/dual_irq_vec_arb.sv
module dual_irq_vec_arb
    import dual_irq_vec_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               status_hi,
    input  logic [NCH-1:0]     tx_ie,
    input  logic [2*NCH-1:0]   rx_mode,
    input  logic [NCH-1:0]     brk_ie,
    input  logic [NCH-1:0]     brk_stat,
    input  logic [NCH-1:0]     rx_set,
    input  logic [NCH-1:0]     rx_clr,
    input  logic [NCH-1:0]     tx_empty,
    input  logic [NCH-1:0]     tx_load,
    input  logic [NCH-1:0]     tx_clr,
    input  logic [NCH-1:0]     svc_rst,
    output logic               irq,
    output logic [VEC_W-1:0]   pend_bits,
    output logic [VEC_W-1:0]   vector
);
    localparam int CH_A = NCH - 1;
    localparam int PB_STRIDE = 3;

    logic [NCH-1:0] irq_c, pb_rx, pb_tx, vwr;
    vkind_e         vkind [NCH];
    vkind_e         sel_kind;
    logic           sel_wr, sel_a;
    logic [VEC_W-1:0] enc_vec, vec_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dual_irq_vec_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_ie    (tx_ie[c]),
            .rx_mode  (rx_mode[2*c +: 2]),
            .brk_ie   (brk_ie[c]),
            .brk_stat (brk_stat[c]),
            .rx_set   (rx_set[c]),
            .rx_clr   (rx_clr[c]),
            .tx_empty (tx_empty[c]),
            .tx_load  (tx_load[c]),
            .tx_clr   (tx_clr[c]),
            .svc_rst  (svc_rst[c]),
            .irq_c    (irq_c[c]),
            .pb_rx    (pb_rx[c]),
            .pb_tx    (pb_tx[c]),
            .vec_wr   (vwr[c]),
            .vec_kind (vkind[c])
        );
    end

    // higher index (channel A) wins a same-cycle vector load
    always_comb begin
        sel_wr   = 1'b0;
        sel_kind = VK_NONE;
        sel_a    = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (vwr[c]) begin
                sel_wr   = 1'b1;
                sel_kind = vkind[c];
                sel_a    = (c == CH_A);
            end
        end
    end

    dual_irq_vec_enc #(.VEC_W(VEC_W)) u_enc (
        .kind   (sel_kind),
        .chan_a (sel_a),
        .hi     (status_hi),
        .vec    (enc_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (sel_wr) vec_q <= enc_vec;
    end

    always_comb begin
        irq       = |irq_c;
        pend_bits = '0;
        for (int c = 0; c < NCH; c++) begin
            pend_bits[PB_STRIDE*c + 1] = pb_tx[c];
            pend_bits[PB_STRIDE*c + 2] = pb_rx[c];
        end
        vector = vec_q;
    end

    a_r2_rx_bit_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_bits[5] && (rx_mode[3:2] == 2'b01 || rx_mode[3:2] == 2'b10)) |-> irq);
    a_r4_vector_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vector) |-> $past(|{rx_set, rx_clr, tx_empty, tx_clr, svc_rst}));
endmodule

// File: tb/dual_irq_vec_arb_tb.sv
`timescale 1ns/1ps
module dual_irq_vec_arb_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic status_hi = 1'b0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk_stat = '0;
    logic [3:0] rx_mode = '0;
    logic [1:0] rx_set = '0, rx_clr = '0, tx_empty = '0, tx_load = '0, tx_clr = '0, svc_rst = '0;
    logic irq;
    logic [7:0] pend_bits, vector;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_irq_vec_arb u_dut (
        .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .tx_ie(tx_ie),
        .rx_mode(rx_mode), .brk_ie(brk_ie), .brk_stat(brk_stat),
        .rx_set(rx_set), .rx_clr(rx_clr), .tx_empty(tx_empty),
        .tx_load(tx_load), .tx_clr(tx_clr), .svc_rst(svc_rst),
        .irq(irq), .pend_bits(pend_bits), .vector(vector)
    );

    // arithmetic model of the requirements
    bit [1:0] m_rp, m_tp, m_rs, m_ts, m_br, m_bt;
    bit [7:0] m_vec;

    // kind: 0 none, 1 rx, 2 tx; ch 1 = A
    function automatic bit [7:0] exp_vec(int kind, int ch, bit hi);
        if (kind == 0) return hi ? 8'h60 : 8'h06;
        if (kind == 2 && ch == 0) return 8'h00;
        if (kind == 1) return hi ? ((ch == 1) ? 8'h30 : 8'h20) : ((ch == 1) ? 8'h0C : 8'h04);
        return hi ? 8'h10 : 8'h08;
    endfunction

    task automatic m_step(int c);
        bit wr = 0;
        int k = 0;
        if (rx_set[c]) begin m_rp[c] = 1; m_rs[c] = 1; m_br[c] = 1; wr = 1; k = 1; end
        if (tx_load[c]) m_tp[c] = 0;
        if (tx_empty[c]) begin
            m_tp[c] = 1;
            if (!m_rs[c]) begin m_ts[c] = 1; if (tx_ie[c]) m_bt[c] = 1; wr = 1; k = 2; end
        end
        if (rx_clr[c]) begin
            m_rp[c] = 0; m_rs[c] = 0; m_br[c] = 0; wr = 1; k = 0;
            if (m_tp[c]) begin m_ts[c] = 1; if (tx_ie[c]) m_bt[c] = 1; k = 2; end
        end
        if (tx_clr[c]) begin
            m_tp[c] = 0; m_ts[c] = 0; m_bt[c] = 0; wr = 1; k = 0;
            if (m_rp[c]) begin m_rs[c] = 1; m_br[c] = 1; k = 1; end
        end
        if (svc_rst[c]) begin
            if (m_rs[c]) begin
                m_rs[c] = 0;
                if (m_tp[c]) begin m_ts[c] = 1; if (tx_ie[c]) m_bt[c] = 1; wr = 1; k = 2; end
            end else m_ts[c] = 0;
        end
        if (wr) m_vec = exp_vec(k, c, status_hi);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rp = 0; m_tp = 0; m_rs = 0; m_ts = 0; m_br = 0; m_bt = 0; m_vec = 0;
        end else begin
            m_step(0);
            m_step(1); // channel A last so its vector load is kept (R11)
        end
    end

    function automatic bit m_irq();
        bit r = 0;
        for (int c = 0; c < 2; c++) begin
            bit en = (rx_mode[2*c +: 2] == 2'b01) || (rx_mode[2*c +: 2] == 2'b10);
            r |= (tx_ie[c] & m_tp[c]) | (en & m_rp[c]) | (brk_ie[c] & brk_stat[c]);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic chk_model(string tag);
        chk({tag, " irq R2"}, {7'd0, irq}, {7'd0, m_irq()});
        chk({tag, " pend R3"}, pend_bits, {2'b00, m_br[1], m_bt[1], 1'b0, m_br[0], m_bt[0], 1'b0});
        chk({tag, " vector R4"}, vector, m_vec);
    endtask

    // drive strobes for one clock, sample at the following falling edge
    task automatic pulse(logic [1:0] rs_, logic [1:0] rc_, logic [1:0] te_,
                         logic [1:0] tl_, logic [1:0] tc_, logic [1:0] sr_);
        rx_set = rs_; rx_clr = rc_; tx_empty = te_; tx_load = tl_; tx_clr = tc_; svc_rst = sr_;
        @(negedge clk);
        rx_set = 0; rx_clr = 0; tx_empty = 0; tx_load = 0; tx_clr = 0; svc_rst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 pend", pend_bits, 8'h00);
        chk("R1 vector", vector, 8'h00);

        tx_ie = 2'b11;
        for (int h = 0; h < 2; h++) begin
            status_hi = h[0];
            pulse(2'b10, 0, 0, 0, 0, 0);
            chk("R5 rxA vec", vector, h ? 8'h30 : 8'h0C); chk("R5 rxA pend", pending_mask(), 8'h20);
            pulse(0, 2'b10, 0, 0, 0, 0);
            chk("R7 none vec", vector, h ? 8'h60 : 8'h06); chk("R7 pend", pending_mask(), 8'h00);
            pulse(0, 0, 2'b10, 0, 0, 0);
            chk("R6 txA vec", vector, h ? 8'h10 : 8'h08); chk("R6 txA pend", pending_mask(), 8'h10);
            pulse(0, 0, 0, 0, 2'b10, 0);
            chk("R8 none vec", vector, h ? 8'h60 : 8'h06);
            pulse(2'b01, 0, 0, 0, 0, 0);
            chk("R4 rxB vec", vector, h ? 8'h20 : 8'h04); chk("R3 rxB pend", pending_mask(), 8'h04);
            pulse(0, 2'b01, 0, 0, 0, 0);
            pulse(0, 0, 2'b01, 0, 0, 0);
            chk("R4 txB vec", vector, 8'h00); chk("R3 txB pend", pending_mask(), 8'h02);
            pulse(0, 0, 0, 0, 2'b01, 0);
            chk("R8 txB cleared", pending_mask(), 8'h00);
        end
        status_hi = 0;

        pulse(2'b10, 0, 0, 0, 0, 0);
        pulse(0, 0, 2'b10, 0, 0, 0);
        chk("R6 tx held vec", vector, 8'h0C); chk("R6 tx held pend", pending_mask(), 8'h20);
        pulse(0, 0, 0, 0, 0, 2'b10);
        chk("R9 tx presented vec", vector, 8'h08); chk("R9 pend", pending_mask(), 8'h30);
        pulse(0, 2'b10, 0, 0, 0, 0);
        chk("R7 tx re-present vec", vector, 8'h08); chk("R7 pend", pending_mask(), 8'h10);
        pulse(0, 0, 0, 0, 2'b10, 0);
        pulse(2'b10, 0, 0, 0, 0, 0);
        pulse(0, 0, 2'b10, 0, 0, 0);
        pulse(0, 0, 0, 0, 2'b10, 0);
        chk("R8 rx re-present vec", vector, 8'h0C); chk("R8 pend", pending_mask(), 8'h20);
        pulse(0, 2'b10, 0, 0, 0, 0);
        pulse(0, 0, 2'b10, 0, 0, 0);
        chk("R10 before irq", {7'd0, irq}, 8'h01);
        pulse(0, 0, 0, 2'b10, 0, 0);
        chk("R10 irq dropped", {7'd0, irq}, 8'h00);
        chk("R10 pend kept", pending_mask(), 8'h10); chk("R10 vec kept", vector, 8'h08);
        pulse(0, 0, 0, 0, 2'b10, 0);

        tx_ie = 0;
        pulse(2'b10, 0, 0, 0, 0, 0);
        rx_mode = 4'b0100; #1 chk("R2 mode01", {7'd0, irq}, 8'h01);
        rx_mode = 4'b1100; #1 chk("R2 mode11", {7'd0, irq}, 8'h00);
        rx_mode = 4'b1000; #1 chk("R2 mode10", {7'd0, irq}, 8'h01);
        rx_mode = 4'b0000; #1 chk("R2 mode00", {7'd0, irq}, 8'h00);
        brk_ie = 2'b01; brk_stat = 2'b01; #1 chk("R2 break B", {7'd0, irq}, 8'h01);
        brk_ie = 0; brk_stat = 0;
        pulse(0, 2'b10, 0, 0, 0, 0);
        @(negedge clk);

        pulse(2'b11, 0, 0, 0, 0, 0);
        chk("R11 A wins vec", vector, 8'h0C);
        pulse(2'b01, 2'b01, 0, 0, 0, 0);
        chk("R11 set then read B", pending_mask(), 8'h20);
        chk_model("directed end");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            if (r[3:0] == 0) begin
                tx_ie = r[5:4]; rx_mode = r[9:6]; brk_ie = r[11:10]; brk_stat = r[13:12]; status_hi = r[14];
            end
            rx_set = r[17:16] & {r[20], r[21]};
            rx_clr = r[19:18] & {r[22], r[23]};
            tx_empty = r[25:24] & {r[20], r[22]};
            tx_load = r[27:26] & {r[21], r[23]} & {r[28], r[28]};
            tx_clr = r[29:28] & {r[30], r[31]} & {r[24], r[25]};
            svc_rst = r[31:30] & {r[17], r[26]};
            @(negedge clk);
            chk_model("sweep");
        end
        rx_set = 0; rx_clr = 0; tx_empty = 0; tx_load = 0; tx_clr = 0; svc_rst = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [7:0] pending_mask();
        return pend_bits;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule